// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block paces periodic temperature conversions and publishes each finished one into a 16-bit result register. A 2-bit resolution code picks how many leading bits of the result carry data: 9, 10, 11 or 12. Each code has its own conversion period, and the period doubles for every added bit. Raw signed samples arrive on an input port with a valid strobe. The block keeps the most recent valid sample. When a conversion closes, it keeps the sample's top bits for the active resolution and clears all bits below them.

The result uses a left-justified two's complement layout. Bit 15 is the sign, bits 14..8 hold whole degrees and bits 7..0 hold fractions of a degree. The 9-, 10-, 11- and 12-bit settings give steps of 0.5, 0.25, 0.125 and 0.0625 degrees. A one-cycle done pulse marks every new result for a downstream thermostat comparator.

A shutdown request never cuts a conversion short. The running conversion closes and stores its result, and only then does the sequencer go to standby. Dropping the request starts a fresh conversion. The resolution code is sampled only when a conversion begins, so a change never alters a conversion already under way.

Top module: `tconv_seq`

## Requirements
- R1: The resolution code maps 00, 01, 10 and 11 to 9, 10, 11 and 12 kept bits. The result equals the captured sample with its top kept bits unchanged and every lower bit zero. Bits 3..0 are therefore always zero. Sample and result share one format: bit 15 is the sign, bits 14..8 are whole degrees, bits 7..0 are the fraction.
- R2: Each conversion with code c lasts BASE_TICKS << c clock cycles. While conversions run back to back, done pulses are spaced by exactly that many cycles.
- R3: After reset, result_o is 0, done_o is 0, busy_o is 1 and standby_o is 0. The first conversion uses the 9-bit setting whatever res_sel_i holds. Its done pulse comes BASE_TICKS cycles after reset is released.
- R4: res_sel_i is sampled only at the clock edge that starts a conversion. A conversion under way keeps the period and truncation it started with.
- R5: A shutdown request lets the running conversion finish, store its result and pulse done, with its full period. From that edge on, busy_o is 0 and standby_o is 1, and no done pulse occurs while in standby.
- R6: Clearing shutdown starts a conversion at the next clock edge, using the res_sel_i value at that edge. Its done pulse comes (BASE_TICKS << c) + 1 cycles after the request is dropped.
- R7: done_o is high for exactly one cycle per stored result. result_o changes only together with done_o and otherwise holds, whatever the sample inputs do.
- R8: sample_i is captured only on cycles with sample_vld_i high. A conversion stores the latest sample captured at or before its closing edge. The capture register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| res_sel_i | input | 2 | Resolution code, sampled when a conversion starts |
| shutdown_i | input | 1 | Standby request, honoured after the running conversion |
| sample_i | input | DATA_W | Raw signed sample |
| sample_vld_i | input | 1 | Qualifies sample_i |
| result_o | output | DATA_W | Latest truncated, left-justified result |
| done_o | output | 1 | One-cycle pulse with each new result |
| busy_o | output | 1 | A conversion is in progress |
| standby_o | output | 1 | The sequencer is idle in shutdown |

## Verification
Every result is due a whole number of cycles after its trigger. After reset release the first one comes after BASE_TICKS cycles. In back-to-back operation each one comes BASE_TICKS << c cycles after the previous done. After shutdown is dropped it comes one cycle more than the period. The bench drives inputs on falling edges and counts falling edges until done_o is seen, so each observed count is compared exactly with these figures. Every result value is read on the falling edge right after the rising edge that stored it. For a resolution change, the closing conversion is checked with the old period and truncation, and the next one with the new.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
   localparam int unsigned NUM_RES = 4;
   localparam int unsigned RES_W   = $clog2(NUM_RES);

   typedef enum logic [RES_W-1:0] {
      RES_9B  = 2'd0,
      RES_10B = 2'd1,
      RES_11B = 2'd2,
      RES_12B = 2'd3
   } res_e;

   typedef enum logic {
      ST_CONV = 1'b0,
      ST_IDLE = 1'b1
   } seq_state_e;
endpackage

// File: rtl/tconv_timer.sv
module tconv_timer
   import tconv_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [RES_W-1:0] res_i,
   output logic             last_o
);
   localparam int unsigned MAX_TICKS = BASE_TICKS << (NUM_RES - 1);
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS);

   generate
      if (BASE_TICKS < 2) begin : g_bad_base
         $error("tconv_timer: BASE_TICKS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   limit;

   always_comb begin
      limit  = (CNT_W + 1)'(BASE_TICKS) << res_i;
      last_o = en_i && ({1'b0, cnt_q} == (limit - 1'b1));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!en_i || last_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: the tick counter never reaches the period of the active setting
   p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, cnt_q} < limit));
endmodule

// File: rtl/tconv_trunc.sv
module tconv_trunc
   import tconv_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned MIN_BITS = 9
) (
   input  logic [DATA_W-1:0] raw_i,
   input  logic [RES_W-1:0]  res_i,
   output logic [DATA_W-1:0] trunc_o
);
   generate
      if (DATA_W <= MIN_BITS + NUM_RES - 1) begin : g_bad_width
         $error("tconv_trunc: DATA_W too small for the widest setting");
      end
   endgenerate

   logic [DATA_W-1:0] keep_tbl [NUM_RES];

   for (genvar r = 0; r < NUM_RES; r++) begin : g_keep
      localparam int unsigned KEEP = MIN_BITS + r;
      localparam int unsigned DROP = DATA_W - KEEP;
      assign keep_tbl[r] = {{KEEP{1'b1}}, {DROP{1'b0}}};
   end

   assign trunc_o = raw_i & keep_tbl[res_i];
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
   import tconv_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             shutdown_i,
   input  logic [RES_W-1:0] res_sel_i,
   input  logic             last_i,
   output logic             busy_o,
   output logic [RES_W-1:0] res_o
);
   seq_state_e state_q;
   res_e       res_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_CONV;
         res_q   <= RES_9B;
      end else if (state_q == ST_CONV) begin
         if (last_i) begin
            if (shutdown_i) begin
               state_q <= ST_IDLE;
            end else begin
               res_q <= res_e'(res_sel_i);
            end
         end
      end else begin
         if (!shutdown_i) begin
            state_q <= ST_CONV;
            res_q   <= res_e'(res_sel_i);
         end
      end
   end

   assign busy_o = (state_q == ST_CONV);
   assign res_o  = res_q;

   // R5: a conversion that has not reached its last tick keeps running
   p_finish_before_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !last_i) |=> busy_o);

   // R4: the active setting is frozen inside a conversion
   p_res_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !last_i) |=> $stable(res_q));
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
   import tconv_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned MIN_BITS   = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        res_sel_i,
   input  logic              shutdown_i,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              sample_vld_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o,
   output logic              busy_o,
   output logic              standby_o
);
   localparam int unsigned ZERO_FLOOR = DATA_W - MIN_BITS - (NUM_RES - 1);

   logic              busy;
   logic              last;
   logic [RES_W-1:0]  res_act;
   logic [DATA_W-1:0] sample_q;
   logic [DATA_W-1:0] captured;
   logic [DATA_W-1:0] trunc;
   logic [DATA_W-1:0] result_q;
   logic              done_q;

   tconv_ctrl u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shutdown_i (shutdown_i),
      .res_sel_i  (res_sel_i),
      .last_i     (last),
      .busy_o     (busy),
      .res_o      (res_act)
   );

   tconv_timer #(
      .BASE_TICKS (BASE_TICKS)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (busy),
      .res_i  (res_act),
      .last_o (last)
   );

   assign captured = sample_vld_i ? sample_i : sample_q;

   tconv_trunc #(
      .DATA_W   (DATA_W),
      .MIN_BITS (MIN_BITS)
   ) u_trunc (
      .raw_i   (captured),
      .res_i   (res_act),
      .trunc_o (trunc)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sample_q <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         sample_q <= captured;
         done_q   <= last;
         if (last) begin
            result_q <= trunc;
         end
      end
   end

   assign result_o  = result_q;
   assign done_o    = done_q;
   assign busy_o    = busy;
   assign standby_o = !busy;

   // R7: the done pulse lasts a single cycle
   p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R7: the published result moves only together with done
   p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(result_o) |-> done_o);

   // R1: the bits below the widest setting always read zero
   p_low_bits_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_o[ZERO_FLOOR-1:0] == '0);

   // R5: no result is published while in standby
   p_quiet_standby_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      standby_o |=> !done_o);
endmodule

// File: tb/tconv_seq_bench.sv
module tconv_seq_bench;
   localparam int BASE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  res_sel = 2'd3;
   logic        shutdown = 1'b0;
   logic [15:0] sample = 16'h0000;
   logic        sample_vld = 1'b0;
   logic [15:0] result;
   logic        done;
   logic        busy;
   logic        standby;

   int nchk = 0;
   int nfail = 0;
   int cur_r = 0;

   always #4ns clk = ~clk;

   tconv_seq #(.BASE_TICKS(BASE)) u_tconv_seq (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .res_sel_i    (res_sel),
      .shutdown_i   (shutdown),
      .sample_i     (sample),
      .sample_vld_i (sample_vld),
      .result_o     (result),
      .done_o       (done),
      .busy_o       (busy),
      .standby_o    (standby)
   );

   function automatic logic [15:0] exp_trunc(logic [15:0] v, int r);
      logic [15:0] m;
      m = 16'hFFFF << (7 - r);
      return v & m;
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!done && n < 2000);
   endtask

   task automatic t_reset();
      check(result == 16'h0, "R3 reset result", result, 0);
      check(done == 1'b0, "R3 reset done", done, 0);
      check(busy == 1'b1 && standby == 1'b0, "R3 reset busy/standby",
            {busy, standby}, 2'b10);
   endtask

   task automatic t_first_conv();
      int n;
      wait_done(n);
      check(n == BASE, "R3 first conversion period", n, BASE);
      check(result == exp_trunc(16'h1917, 0), "R3 R1 first result 9-bit",
            result, exp_trunc(16'h1917, 0));
      @(negedge clk);
      check(done == 1'b0, "R7 done width", done, 0);
      wait_done(n);
      check(n == (BASE << 3) - 1, "R4 R2 12-bit period after switch", n + 1, BASE << 3);
      check(result == exp_trunc(16'h1917, 3), "R1 12-bit result",
            result, exp_trunc(16'h1917, 3));
      cur_r = 3;
   endtask

   task automatic t_res_step(int r, logic [15:0] v);
      int n;
      res_sel = r[1:0];
      sample  = v;
      wait_done(n);
      check(n == (BASE << cur_r), "R4 old period kept", n, BASE << cur_r);
      check(result == exp_trunc(v, cur_r), "R4 old truncation kept",
            result, exp_trunc(v, cur_r));
      wait_done(n);
      check(n == (BASE << r), "R2 period for new code", n, BASE << r);
      check(result == exp_trunc(v, r), "R1 truncation for new code",
            result, exp_trunc(v, r));
      cur_r = r;
   endtask

   task automatic t_valid_gate();
      int n;
      sample     = 16'h0A2F;
      sample_vld = 1'b1;
      @(negedge clk);
      sample_vld = 1'b0;
      sample     = 16'h55AA;
      wait_done(n);
      wait_done(n);
      check(result == exp_trunc(16'h0A2F, cur_r), "R8 only valid samples captured",
            result, exp_trunc(16'h0A2F, cur_r));
   endtask

   task automatic t_shutdown();
      int n;
      logic [15:0] held;
      repeat (3) @(negedge clk);
      shutdown   = 1'b1;
      sample     = 16'hE6F3;
      sample_vld = 1'b1;
      wait_done(n);
      check(n + 3 == (BASE << cur_r), "R5 running conversion completes",
            n + 3, BASE << cur_r);
      check(result == exp_trunc(16'hE6F3, cur_r), "R5 final result stored",
            result, exp_trunc(16'hE6F3, cur_r));
      check(standby == 1'b1 && busy == 1'b0, "R5 standby entered",
            {standby, busy}, 2'b10);
      held = result;
      n = 0;
      for (int i = 0; i < 40; i++) begin
         sample = 16'h3000 + 16'(i);
         @(negedge clk);
         if (done) n++;
      end
      check(n == 0, "R5 no done in standby", n, 0);
      check(result == held, "R7 result holds in standby", result, held);
      sample   = 16'h0A2F;
      res_sel  = 2'd2;
      shutdown = 1'b0;
      wait_done(n);
      check(n == (BASE << 2) + 1, "R6 resume period", n, (BASE << 2) + 1);
      check(result == exp_trunc(16'h0A2F, 2), "R6 resume uses new code",
            result, exp_trunc(16'h0A2F, 2));
      check(busy == 1'b1, "R6 busy after resume", busy, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      sample     = 16'h1917;
      sample_vld = 1'b1;
      rst_n      = 1'b1;
      t_reset();
      t_first_conv();
      t_res_step(1, 16'hF5E7);
      t_res_step(2, 16'h7D5B);
      t_res_step(0, 16'hC937);
      t_valid_gate();
      t_shutdown();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule